// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two 8-bit buses, called A and B. Each bus has its own holding register with its own clock. A rising edge on that clock stores the bus value, and the enable and direction inputs have no say in this. A single active-low enable and a direction input decide which of three states the block is in:

- Neither bus is driven.
- B is driven from the A side.
- A is driven from the B side.

Each direction has its own select input. The select chooses whether the driven bus carries the live value of the opposite bus or the value held in the opposite side's register.

The tri-state pins are split into three signals per bus: input data, output data and output enable. When a bus is not driven, its output data is held at zero. The output path is purely combinational, so the live mode adds no clock latency. An active-low asynchronous reset clears both registers.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, both holding registers read zero. A stored-mode output therefore shows 8'h00 right after reset.
- R2: A rising edge of `clk_a` loads `a_in` into the A-side register, whatever the values of `en_n` and `to_b`.
- R3: A rising edge of `clk_b` loads `b_in` into the B-side register, whatever the values of `en_n` and `to_b`.
- R4: With `en_n` = 1, `a_oe` = 0, `b_oe` = 0, `a_out` = 0 and `b_out` = 0.
- R5: With `en_n` = 0 and `to_b` = 1: `b_oe` = 1, `a_oe` = 0 and `a_out` = 0.
- R6: With `en_n` = 0 and `to_b` = 0: `a_oe` = 1, `b_oe` = 0 and `b_out` = 0.
- R7: While driving B with `ab_stored` = 0, `b_out` equals the current `a_in`, with no clock needed.
- R8: While driving B with `ab_stored` = 1, `b_out` equals the A-side register.
- R9: While driving A with `ba_stored` = 0, `a_out` equals the current `b_in`, with no clock needed.
- R10: While driving A with `ba_stored` = 1, `a_out` equals the B-side register.
- R11: In stored mode, a rising edge on the source-side clock shows the newly loaded value on the driven bus before that clock falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_a | input | 1 | Load clock of the A-side register |
| clk_b | input | 1 | Load clock of the B-side register |
| en_n | input | 1 | Active-low output enable; high isolates both buses |
| to_b | input | 1 | Direction: 1 drives B, 0 drives A |
| ab_stored | input | 1 | A-to-B source: 0 live A bus, 1 A-side register |
| ba_stored | input | 1 | B-to-A source: 0 live B bus, 1 B-side register |
| a_in | input | 8 | Data arriving on bus A |
| a_out | output | 8 | Data driven onto bus A (zero when not driven) |
| a_oe | output | 1 | Bus A driver enable |
| b_in | input | 8 | Data arriving on bus B |
| b_out | output | 8 | Data driven onto bus B (zero when not driven) |
| b_oe | output | 1 | Bus B driver enable |

## Verification
The enables, and the live-mode outputs, respond to their inputs with no latency. The bench therefore samples them a short settle delay after the inputs change, and never on a clock edge. A register loads at the rising edge of its clock, so a stored-mode output is due just after that edge. For R11 the bench samples while the clock is still high, and it samples the other stored-mode checks after the pulse has ended. The sweep visits all 16 combinations of enable, direction and both selects with a dozen data patterns. A register model in the bench follows every clock pulse, and the expected outputs are derived from that model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    XM_ISOLATE = 2'd0,
    XM_DRIVE_A = 2'd1,
    XM_DRIVE_B = 2'd2
  } xmode_t;

  // Output-control decode: enable is active low, direction high selects B.
  function automatic xmode_t decode_mode(input logic en_n, input logic to_b);
    if (en_n)      return XM_ISOLATE;
    else if (to_b) return XM_DRIVE_B;
    else           return XM_DRIVE_A;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Loads on every rising edge; no enable qualifies the capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_side.sv
module xcvr_side #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         use_reg,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] dout
);
  logic [W-1:0] picked;

  always_comb begin
    picked = use_reg ? held : live;
    dout   = drive ? picked : '0;
  end
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         en_n,
  input  logic         to_b,
  input  logic         ab_stored,
  input  logic         ba_stored,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;

  xmode_t       mode;
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic         drive_a;
  logic         drive_b;

  assign mode    = decode_mode(en_n, to_b);
  assign drive_a = (mode == XM_DRIVE_A);
  assign drive_b = (mode == XM_DRIVE_B);
  assign a_oe    = drive_a;
  assign b_oe    = drive_b;

  xcvr_store #(.W(W)) u_reg_a (.clk(clk_a), .rst_n(rst_n), .d(a_in), .q(a_q));
  xcvr_store #(.W(W)) u_reg_b (.clk(clk_b), .rst_n(rst_n), .d(b_in), .q(b_q));

  // B is fed from the A side, A is fed from the B side.
  xcvr_side #(.W(W)) u_to_b (
    .drive(drive_b), .use_reg(ab_stored), .live(a_in), .held(a_q), .dout(b_out)
  );
  xcvr_side #(.W(W)) u_to_a (
    .drive(drive_a), .use_reg(ba_stored), .live(b_in), .held(b_q), .dout(a_out)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_a,
  input logic         clk_b,
  input logic         en_n,
  input logic         to_b,
  input logic         ab_stored,
  input logic         ba_stored,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_oe,
  input logic         b_oe,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);
  logic a_seen;
  logic b_seen;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) a_seen <= 1'b0; else a_seen <= 1'b1;
  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_seen <= 1'b0; else b_seen <= 1'b1;

  // R2
  a_capture_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_seen |-> (a_q == $past(a_in)));

  // R3
  b_capture_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_seen |-> (b_q == $past(b_in)));

  // R4
  isolate_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  // R5
  drive_b_oe_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!en_n && to_b) |-> (b_oe && !a_oe && a_out == '0));

  // R6
  drive_a_oe_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!en_n && !to_b) |-> (a_oe && !b_oe && b_out == '0));

  // R7
  live_ab_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!en_n && to_b && !ab_stored) |-> (b_out == a_in));

  // R8
  held_ab_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!en_n && to_b && ab_stored) |-> (b_out == a_q));

  // R9
  live_ba_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!en_n && !to_b && !ba_stored) |-> (a_out == b_in));

  // R10
  held_ba_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!en_n && !to_b && ba_stored) |-> (a_out == b_q));

  // R5 R6: at most one bus is driven
  one_driver_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0({a_oe, b_oe}));

endmodule

bind dual_bus_xcvr xcvr_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .en_n(en_n), .to_b(to_b),
  .ab_stored(ab_stored), .ba_stored(ba_stored), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
  .a_q(a_q), .b_q(b_q)
);

// File: tb/dual_bus_xcvr_bench.sv
module dual_bus_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clk_a, clk_b, en_n, to_b, ab_stored, ba_stored;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  int total = 0;
  int bad = 0;
  logic [W-1:0] ra, rb;

  dual_bus_xcvr #(.W(W)) u_dual_bus_xcvr (
    .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b), .en_n(en_n), .to_b(to_b),
    .ab_stored(ab_stored), .ba_stored(ba_stored), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk); clk_a = 1'b1; ra = a_in;
    @(posedge clk); #2 clk_a = 1'b0;
  endtask

  task automatic pulse_b();
    @(negedge clk); clk_b = 1'b1; rb = b_in;
    @(posedge clk); #2 clk_b = 1'b0;
  endtask

  // Expected outputs derived from the requirements and the bench register model.
  task automatic check_all();
    logic [W-1:0] ea, eb;
    logic eoa, eob;
    string tg;
    #3;
    eoa = !en_n && !to_b;
    eob = !en_n && to_b;
    eb  = eob ? (ab_stored ? ra : a_in) : '0;
    ea  = eoa ? (ba_stored ? rb : b_in) : '0;
    if (en_n) tg = "R4";
    else if (to_b) tg = ab_stored ? "R5/R8" : "R5/R7";
    else tg = ba_stored ? "R6/R10" : "R6/R9";
    check({tg, " a_oe"}, {7'd0, a_oe}, {7'd0, eoa});
    check({tg, " b_oe"}, {7'd0, b_oe}, {7'd0, eob});
    check({tg, " a_out"}, a_out, ea);
    check({tg, " b_out"}, b_out, eb);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_a = 0; clk_b = 0; en_n = 0; to_b = 1;
    ab_stored = 1; ba_stored = 1; a_in = 8'hA5; b_in = 8'h5A;
    ra = '0; rb = '0;
    #25;
    // R1: registers cleared while reset is held
    check("R1 b_out stored", b_out, 8'h00);
    to_b = 0; #3;
    check("R1 a_out stored", a_out, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #5;

    // R2: capture while isolated, then read through stored A-to-B path
    en_n = 1; a_in = 8'h96; pulse_a();
    en_n = 0; to_b = 1; ab_stored = 1; a_in = 8'h00; #3;
    check("R2 capture ignoring enable", b_out, 8'h96);
    // R3: capture while driving B, then read through stored B-to-A path
    b_in = 8'h3B; pulse_b();
    to_b = 0; ba_stored = 1; b_in = 8'h00; #3;
    check("R3 capture ignoring direction", a_out, 8'h3B);

    // R11: new value visible while source clock is still high
    to_b = 1; ab_stored = 1; a_in = 8'hC3;
    @(negedge clk); clk_a = 1'b1; ra = a_in; #2;
    check("R11 A->B update on edge", b_out, 8'hC3);
    @(posedge clk); #2 clk_a = 1'b0;
    to_b = 0; ba_stored = 1; b_in = 8'h7E;
    @(negedge clk); clk_b = 1'b1; rb = b_in; #2;
    check("R11 B->A update on edge", a_out, 8'h7E);
    @(posedge clk); #2 clk_b = 1'b0;

    // Sweep of every control combination over several data patterns
    for (int p = 0; p < 12; p++) begin
      for (int m = 0; m < 16; m++) begin
        {en_n, to_b, ab_stored, ba_stored} = 4'(m);
        a_in = 8'((p * 37 + 5) ^ (m * 11));
        b_in = 8'((p * 53 + 9) + m * 7);
        if (((p + m) % 3) == 0) pulse_a();
        if (((p + m) % 3) == 1) pulse_b();
        a_in = 8'(a_in + 8'd1);
        b_in = 8'(b_in ^ 8'hFF);
        check_all();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule